// File: doc/BRIEF.md
# 16-bit programmable pulse generator

The block is an up-counting 16-bit timer that draws a repeating pulse on one pin. Two compare values govern the waveform: one marks the count at which the output flip-flop turns over inside the period, the other marks the end of the period. At the period match the flip-flop turns over again, the counter restarts from zero and a one-cycle interrupt strobe is raised.

The pin drives the inverse of the flip-flop. A host programs the block over a narrow 8-bit write bus. Each compare value is written as two bytes, low byte first. A control byte starts and stops the timer, selects the count source and sets the level the flip-flop takes on start.

The count source is either a prescaled internal tick or an external clock. The external clock passes through a synchroniser that is sampled at the machine-cycle rate. Each rising edge seen there advances the counter by one. When the timer stops, the counter and the pin keep their values.

Top module: `pulse_gen16`

## Requirements
- R1: After reset the flip-flop is 0, so `pulse_out` is 1. `irq` is 0, the timer is stopped and both compare values are 0.
- R2: Register addresses are 0 = width low, 1 = width high, 2 = period low, 3 = period high and 4 = control. A low-byte write is only held. The 16-bit compare value changes only when its high byte is written, combined with the held low byte.
- R3: On a count step that brings the counter to the width value (and not to the period value), the flip-flop inverts and the counter keeps that value.
- R4: On a count step that brings the counter to the period value, the flip-flop inverts and the counter returns to 0. `irq` is high for exactly the one cycle after that clock edge.
- R5: `pulse_out` is always the inverse of the flip-flop. A control write with bit 0 = 1 while stopped starts the timer, clears the counter and loads the flip-flop from control bit 2.
- R6: A control write with bit 0 = 0 stops the timer. While stopped, the counter and `pulse_out` hold their values whatever the count inputs do.
- R7: A compare value committed while the timer runs is used from the next count step. There is no buffering.
- R8: With control bit 1 = 0, the counter advances only in cycles where `tick_int` is 1.
- R9: With control bit 1 = 1, `ext_clk` is shifted through three stages only in cycles where `mc_en` is 1. A rising edge seen between the second and third stage, in a cycle with `mc_en` = 1, is one count step. Edges that occur while `mc_en` is 0 and are gone again before `mc_en` returns to 1 are not counted.
- R10: When width equals period, the period match wins. The step gives a single inversion and one `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_int | input | 1 | Prescaled internal count enable |
| mc_en | input | 1 | Machine-cycle enable for external clock sampling |
| ext_clk | input | 1 | External count clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pulse_out | output | 1 | Pulse pin, inverse of the output flip-flop |
| irq | output | 1 | One-cycle end-of-period strobe |

## Verification
The period match and the width match can both fall on the same count step, because both compare the same incremented value. This is provoked by setting width equal to period. The waveform must then show a single inversion together with one `irq` each period, never a double inversion. A second collision comes from committing a new period while the counter runs. The next period match must follow the new value from the very next count step.

// File: rtl/pulse_gen16.sv
module pulse_gen16 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_int,
  input  logic       mc_en,
  input  logic       ext_clk,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       pulse_out,
  output logic       irq
);
  localparam int CW = 16;

  logic [CW-1:0] width_r, period_r, cnt;
  logic [7:0]    wlo_hold, plo_hold;
  logic          run, ext_sel, ff, irq_q;
  logic [2:0]    sync;

  wire           ctrl_wr  = wr_en && (wr_addr == 3'd4);
  wire           start    = ctrl_wr && wr_data[0] && !run;
  wire           ext_rise = mc_en && sync[1] && !sync[2];
  wire           cnt_en   = run && (ext_sel ? ext_rise : tick_int);
  wire [CW-1:0]  nxt      = cnt + 1'b1;
  wire           hit_p    = (nxt == period_r);
  wire           hit_w    = (nxt == width_r);

  assign pulse_out = ~ff;
  assign irq       = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_r  <= '0;
      period_r <= '0;
      wlo_hold <= '0;
      plo_hold <= '0;
      run      <= 1'b0;
      ext_sel  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: wlo_hold <= wr_data;
        3'd1: width_r  <= {wr_data, wlo_hold};
        3'd2: plo_hold <= wr_data;
        3'd3: period_r <= {wr_data, plo_hold};
        3'd4: begin
          run     <= wr_data[0];
          ext_sel <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sync <= '0;
    else if (mc_en) sync <= {sync[1:0], ext_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ff    <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= cnt_en && hit_p;
      if (start) begin
        cnt <= '0;
        ff  <= wr_data[2];
      end else if (cnt_en) begin
        if (hit_p) begin
          cnt <= '0;
          ff  <= ~ff;
        end else begin
          cnt <= nxt;
          if (hit_w) ff <= ~ff;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_gen16_chk.sv
module pulse_gen16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        mc_en,
  input logic [2:0]  sync,
  input logic        cnt_en,
  input logic [15:0] cnt,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic        pulse_out,
  input logic        irq
);
  a_r4_irq_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cnt_en));

  a_r4_irq_counter_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == 16'd0));

  a_r5_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4 && wr_data[0] && !run)
      |=> (pulse_out == !$past(wr_data[2])) && (cnt == 16'd0));

  a_r6_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && wr_addr == 3'd4)) |=> $stable(pulse_out) && $stable(cnt));

  a_r8_no_step_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_en) |=> $stable(cnt));

  a_r9_sync_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_en |=> $stable(sync));
endmodule

bind pulse_gen16 pulse_gen16_chk chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .mc_en(mc_en), .sync(sync),
  .cnt_en(cnt_en), .cnt(cnt), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pulse_out(pulse_out), .irq(irq)
);

// File: tb/pulse_gen16_tb_top.sv
module pulse_gen16_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic tick_int = 0, mc_en = 0, ext_clk = 0, wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic pulse_out, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  logic [15:0] m_cnt = 0, m_wid = 0, m_per = 0;
  logic [7:0]  m_wlo = 0, m_plo = 0;
  logic        m_run = 0, m_sel = 0, m_ff = 0;
  logic [2:0]  m_sync = 0;

  pulse_gen16 dut_i (
    .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .mc_en(mc_en),
    .ext_clk(ext_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pulse_out(pulse_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input logic tk, input logic ex, input logic mc,
                      input logic we, input logic [2:0] a, input logic [7:0] d,
                      input string tag);
    logic        rise, en, m_irq;
    logic [15:0] nx;
    @(negedge clk);
    tick_int = tk; ext_clk = ex; mc_en = mc; wr_en = we; wr_addr = a; wr_data = d;
    rise  = mc && m_sync[1] && !m_sync[2];
    en    = m_run && (m_sel ? rise : tk);
    nx    = m_cnt + 16'd1;
    m_irq = 1'b0;
    if (we && a == 3'd4 && d[0] && !m_run) begin
      m_cnt = 0; m_ff = d[2];
    end else if (en) begin
      if (nx == m_per) begin m_cnt = 0; m_ff = !m_ff; m_irq = 1'b1; end
      else begin m_cnt = nx; if (nx == m_wid) m_ff = !m_ff; end
    end
    if (mc) m_sync = {m_sync[1:0], ex};
    if (we) begin
      case (a)
        3'd0: m_wlo = d;
        3'd1: m_wid = {d, m_wlo};
        3'd2: m_plo = d;
        3'd3: m_per = {d, m_plo};
        3'd4: begin m_run = d[0]; m_sel = d[1]; end
        default: ;
      endcase
    end
    exp_q.push_back({!m_ff, m_irq});
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    step(0, 0, 1, 1, a, d, tag);
  endtask

  task automatic run_ticks(input int n, input int every, input string tag);
    for (int i = 0; i < n; i++) step((i % every) == 0, 0, 1, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({pulse_out, irq} !== e) begin
        errors++;
        $display("FAIL %s: pulse_out/irq actual %b%b expected %b%b at %0t",
                 t, pulse_out, irq, e[1], e[0], $time);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pulse_out !== 1'b1 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual %b%b expected 10", pulse_out, irq);
    end
    rst_n = 1;
    run_ticks(4, 1, "R1");
    // R2: low byte alone must not change width
    wr(0, 8'd3, "R2"); wr(1, 8'd0, "R2");
    wr(2, 8'd8, "R2"); wr(3, 8'd0, "R2");
    wr(0, 8'd5, "R2");
    wr(4, 8'h01, "R5");
    run_ticks(20, 1, "R3");
    run_ticks(30, 3, "R8");
    // R6: stop and hold
    run_ticks(2, 1, "R4");
    wr(4, 8'h00, "R6");
    run_ticks(10, 1, "R6");
    wr(4, 8'h05, "R5");
    run_ticks(20, 1, "R5");
    // R7: new period while running
    wr(2, 8'd12, "R7"); wr(3, 8'd0, "R7");
    run_ticks(40, 1, "R7");
    // R10: width equals period
    wr(4, 8'h00, "R10");
    wr(0, 8'd6, "R10"); wr(1, 8'd0, "R10");
    wr(2, 8'd6, "R10"); wr(3, 8'd0, "R10");
    wr(4, 8'h01, "R10");
    run_ticks(30, 1, "R10");
    // R9: external clock source
    wr(4, 8'h00, "R9");
    wr(0, 8'd2, "R9"); wr(2, 8'd4, "R9");
    wr(1, 8'd0, "R9"); wr(3, 8'd0, "R9");
    wr(4, 8'h03, "R9");
    for (int i = 0; i < 80; i++) step(0, (i / 4) % 2, 1, 0, 0, 0, "R9");
    for (int i = 0; i < 40; i++) step(1, i % 2, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 40; i++) step(0, (i / 3) % 2, 1, 0, 0, 0, "R9");
    step(0, 0, 1, 0, 0, 0, "R9");
    @(posedge clk); #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule